// File: doc/BRIEF.md
# Flash status bit generator

This block sits on the read path of a byte-wide flash array and reports what the internal write engine is doing. It accepts start pulses for three operations: byte-program, whole-array erase and sector erase. Each pulse comes with a target address and data byte. A pulse tick from a stand-in program/erase engine advances each operation one pulse at a time. A small behavioural array holds the stored bytes.

When no operation runs, a read returns the stored byte. From the clock edge that accepts a start until the operation ends, a read returns a status byte instead:

- Bit 7 is the polling bit. It is the complement of the bit being programmed, or 0 while erasing the addressed sector.
- Bit 6 inverts on every read.
- Bit 5 flags a program that ran past its pulse limit.
- Bit 3 reports whether the sector-erase address-load window has closed.

The load window lasts 80 µs. Its length is counted in clock cycles from the clock frequency parameter. More sector-erase commands issued inside the window add their sectors and restart the window. Only a reset leaves the failed state.

Top module: `flash_status_gen`

## Requirements
- R1: On rst_n low: rd_data becomes 0x00, any operation and the failure flag are cleared, and the bit-6 toggle flop returns to 0. Array contents are kept.
- R2: During a byte-program, status bit 7 is the complement of bit 7 of the byte being programmed. After completion, a read of that address returns the programmed byte.
- R3: During an erase, status bit 7 is 0 when the read address lies in a sector selected for erase and 1 otherwise. The sector is rd_addr[ADDR_W-1 -: SECT_W], and every sector counts as selected for a whole-array erase. On completion, every byte in the selected sectors reads 0xFF.
- R4: Each status read returns the toggle flop on bit 6 and then inverts it. Two consecutive status reads therefore differ in bit 6. After completion, repeated reads of one address return the same byte.
- R5: A program in which no bit has to go from 0 to 1 completes on the PROG_PULSES-th pulse tick. Before that, reads still return status.
- R6: A program that needs a 0-to-1 change sets status bit 5 on pulse tick PULSE_MAX+1. From then on, bit 7 keeps its in-progress value, bit 6 keeps toggling, further ticks change nothing, and the stored byte is unchanged. After a reset, the byte can be programmed normally.
- R7: Status bit 3 stays 0 for WIN_CYC = CLK_KHZ*WIN_US/1000 cycles after the edge that accepted the latest sector-erase command. A read sampled on the WIN_CYC-th edge after it still shows 0, and a read sampled one edge later shows 1. Bit 3 is 1 throughout a whole-array erase and 0 during a program.
- R8: A sector-erase command accepted while the window is open adds its sector and restarts the window. A sector-erase command after the window has closed is ignored.
- R9: Pulse ticks during the load window are ignored. A sector erase completes on the ERASE_PULSES-th tick after the window closes, and a whole-array erase on its ERASE_PULSES-th tick.
- R10: Any start pulse other than those covered by R8 is ignored while an operation runs or the failure flag is set.
- R11: The status byte carries zeros on bits 4, 2, 1 and 0. rd_data updates on the edge that samples rd_en and holds otherwise.
- R12: With no operation running, a read returns the stored byte. A whole-array erase sets every byte to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low device reset |
| prog_start | input | 1 | Start a byte-program at cmd_addr with cmd_data |
| chip_erase_start | input | 1 | Start a whole-array erase |
| sect_erase_start | input | 1 | Start, or add to, a sector erase of the sector holding cmd_addr |
| cmd_addr | input | ADDR_W | Target address of a start pulse |
| cmd_data | input | 8 | Byte to program |
| pulse_tick | input | 1 | One program/erase pulse from the engine stub |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read data: array byte or status byte |

## Verification
The bench restarts the load window with a second sector command partway through. It then samples bit 3 exactly on the last open edge and on the one after it, so a timer that is not restarted, or that is off by one cycle, shows 1 too early or 0 too late. Pulse ticks are fed into the open window, so a design that counts them finishes the erase early and returns array data where status is expected. A program that needs a 0-to-1 change is pulsed up to and past the limit: a design that completes it anyway, flags it one pulse early, or freezes the toggle bit fails the reads around the limit. Start pulses are issued while an operation runs and again after the window has closed, and the reads afterwards show whether any of them altered the array or the sector selection.

// File: rtl/flash_status_gen.sv
`timescale 1ns/1ps
module flash_status_gen #(
  parameter int ADDR_W       = 8,
  parameter int SECT_W       = 2,
  parameter int CLK_KHZ      = 200000,
  parameter int WIN_US       = 80,
  parameter int PROG_PULSES  = 2,
  parameter int ERASE_PULSES = 4,
  parameter int PULSE_MAX    = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_start,
  input  logic              chip_erase_start,
  input  logic              sect_erase_start,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic              pulse_tick,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int NSECT   = 1 << SECT_W;
  localparam int SECT_SH = ADDR_W - SECT_W;
  localparam int WIN_CYC = CLK_KHZ * WIN_US / 1000;
  localparam int TMR_W   = $clog2(WIN_CYC + 1);
  localparam int CNT_W   = $clog2(PULSE_MAX + ERASE_PULSES + 2);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(WIN_CYC - 1);
  localparam logic [CNT_W-1:0] N_PROG   = CNT_W'(PROG_PULSES);
  localparam logic [CNT_W-1:0] N_ERASE  = CNT_W'(ERASE_PULSES);
  localparam logic [CNT_W-1:0] N_MAX    = CNT_W'(PULSE_MAX);

  typedef enum logic [2:0] {S_IDLE, S_PROG, S_LOAD, S_SERASE, S_CERASE, S_FAIL} st_t;

  st_t               st;
  logic [ADDR_W-1:0] tgt_addr;
  logic [7:0]        tgt_data;
  logic [NSECT-1:0]  sect_mask;
  logic [TMR_W-1:0]  tmr;
  logic [CNT_W-1:0]  cnt;
  logic              tgl;
  logic [7:0]        mem [DEPTH];
  logic [DEPTH-1:0]  byte_sel;

  wire busy     = st != S_IDLE;
  wire erasing  = st == S_LOAD || st == S_SERASE || st == S_CERASE;
  wire in_sel   = st == S_CERASE || sect_mask[rd_addr[ADDR_W-1 -: SECT_W]];
  wire prog_ok  = ((~mem[tgt_addr]) & tgt_data) == 8'h00;
  wire [CNT_W-1:0] cnt_nx = cnt + 1'b1;
  wire [NSECT-1:0] cmd_sel = NSECT'(1) << cmd_addr[ADDR_W-1 -: SECT_W];

  wire dq7 = erasing ? ~in_sel : ~tgt_data[7];
  wire dq5 = st == S_FAIL;
  wire dq3 = st == S_SERASE || st == S_CERASE;
  wire [7:0] status = {dq7, tgl, dq5, 1'b0, dq3, 3'b000};

  wire prog_done  = st == S_PROG && pulse_tick && prog_ok && cnt_nx == N_PROG;
  wire prog_fail  = st == S_PROG && pulse_tick && !prog_ok && cnt_nx > N_MAX;
  wire erase_done = (st == S_SERASE || st == S_CERASE) && pulse_tick && cnt_nx == N_ERASE;

  for (genvar g = 0; g < DEPTH; g++) begin : g_sel
    localparam int SG = g >> SECT_SH;
    assign byte_sel[g] = st == S_CERASE || sect_mask[SG];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tgt_addr  <= '0;
      tgt_data  <= '0;
      sect_mask <= '0;
      tmr       <= '0;
      cnt       <= '0;
      tgl       <= 1'b0;
      rd_data   <= '0;
    end else begin
      if (rd_en) begin
        rd_data <= busy ? status : mem[rd_addr];
        if (busy) tgl <= ~tgl;
      end
      unique case (st)
        S_IDLE: begin
          cnt <= '0;
          tmr <= '0;
          if (prog_start) begin
            st       <= S_PROG;
            tgt_addr <= cmd_addr;
            tgt_data <= cmd_data;
          end else if (chip_erase_start) begin
            st <= S_CERASE;
          end else if (sect_erase_start) begin
            st        <= S_LOAD;
            sect_mask <= cmd_sel;
          end
        end
        S_PROG: begin
          if (prog_done)      st  <= S_IDLE;
          else if (prog_fail) st  <= S_FAIL;
          else if (pulse_tick) cnt <= cnt_nx;
        end
        S_LOAD: begin
          if (sect_erase_start) begin
            sect_mask <= sect_mask | cmd_sel;
            tmr       <= '0;
          end else if (tmr == TMR_LAST) begin
            st <= S_SERASE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_SERASE, S_CERASE: begin
          if (erase_done)      st  <= S_IDLE;
          else if (pulse_tick) cnt <= cnt_nx;
        end
        S_FAIL: ;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    for (int i = 0; i < DEPTH; i++)
      if (erase_done && byte_sel[i[ADDR_W-1:0]])
        mem[i[ADDR_W-1:0]] <= 8'hFF;
      else if (prog_done && tgt_addr == i[ADDR_W-1:0])
        mem[i[ADDR_W-1:0]] <= tgt_data;

  a_r6_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_FAIL |=> st == S_FAIL);

  a_r2_prog_poll: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && st == S_PROG) |=> rd_data[7] == ~tgt_data[7]);

  a_r4_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy) |=> tgl != $past(tgl));

  a_r8_late_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SERASE && sect_erase_start) |=> $stable(sect_mask));

  a_r7_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_LOAD |-> tmr <= TMR_LAST);

  a_r10_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PROG && !pulse_tick) |=> st == S_PROG && $stable(tgt_addr) && $stable(tgt_data));

  a_r11_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy) |=> rd_data[4] == 1'b0 && rd_data[2:0] == 3'b000);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/flash_status_gen_tb_top.sv
`timescale 1ns/1ps
module flash_status_gen_tb_top;
  localparam int AW = 6, SW = 2, CK = 250, WU = 80, PP = 2, EP = 3, PM = 5;
  localparam int WIN = CK * WU / 1000;
  localparam int DEP = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic prog_start = 1'b0, chip_erase_start = 1'b0, sect_erase_start = 1'b0;
  logic pulse_tick = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] cmd_addr = '0, rd_addr = '0;
  logic [7:0] cmd_data = '0;
  logic [7:0] rd_data;
  logic [7:0] model [DEP];
  logic tg = 1'b0;
  int nchk = 0, nerr = 0;

  always #2.5 clk = ~clk;

  flash_status_gen #(.ADDR_W(AW), .SECT_W(SW), .CLK_KHZ(CK), .WIN_US(WU),
    .PROG_PULSES(PP), .ERASE_PULSES(EP), .PULSE_MAX(PM)) dut_i (
    .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .chip_erase_start(chip_erase_start),
    .sect_erase_start(sect_erase_start), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .pulse_tick(pulse_tick), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    rd_addr = a; rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; v = rd_data;
  endtask

  task automatic rd_arr(input string tag, input logic [AW-1:0] a);
    logic [7:0] v;
    rd(a, v); check(tag, v, model[a]);
  endtask

  task automatic rd_stat(input string tag, input logic [AW-1:0] a,
                         input logic b7, input logic b5, input logic b3);
    logic [7:0] v;
    rd(a, v); check(tag, v, {b7, tg, b5, 1'b0, b3, 3'b000}); tg = ~tg;
  endtask

  task automatic pulse(); pulse_tick = 1'b1; @(negedge clk); pulse_tick = 1'b0; endtask

  task automatic start_prog(input logic [AW-1:0] a, input logic [7:0] d);
    cmd_addr = a; cmd_data = d; prog_start = 1'b1; @(negedge clk); prog_start = 1'b0;
  endtask

  task automatic start_chip();
    chip_erase_start = 1'b1; @(negedge clk); chip_erase_start = 1'b0;
  endtask

  task automatic start_sect(input logic [AW-1:0] a);
    cmd_addr = a; sect_erase_start = 1'b1; @(negedge clk); sect_erase_start = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] d2;
    cyc(3); rst_n = 1'b1;
    check("R1 reset rd_data", rd_data, 8'h00);

    start_chip();
    rd_stat("R12 R3 chip busy", 0, 1'b0, 1'b0, 1'b1);
    rd_stat("R4 toggle second read", 37, 1'b0, 1'b0, 1'b1);
    pulse(); pulse();
    rd_stat("R9 chip one tick short", 63, 1'b0, 1'b0, 1'b1);
    pulse();
    for (int i = 0; i < DEP; i++) model[i] = 8'hFF;
    for (int i = 0; i < DEP; i++) rd_arr("R12 chip erased", AW'(i));

    for (int a = 0; a < DEP; a++) begin
      logic [7:0] d;
      d = 8'((a * 37 + 11) & 255);
      start_prog(AW'(a), d);
      rd_stat("R2 R11 program busy", AW'(a), ~d[7], 1'b0, 1'b0);
      rd_stat("R4 program toggle", AW'(a), ~d[7], 1'b0, 1'b0);
      pulse();
      rd_stat("R5 one pulse short", AW'(a), ~d[7], 1'b0, 1'b0);
      pulse();
      model[a] = d;
      rd_arr("R2 programmed byte", AW'(a));
      rd_arr("R4 settled", AW'(a));
    end

    d2 = model[10] & 8'h0F;
    start_prog(10, d2);
    cmd_addr = 11; cmd_data = 8'h00;
    prog_start = 1'b1; chip_erase_start = 1'b1; sect_erase_start = 1'b1;
    @(negedge clk);
    prog_start = 1'b0; chip_erase_start = 1'b0; sect_erase_start = 1'b0;
    rd_stat("R10 still programming", 10, ~d2[7], 1'b0, 1'b0);
    pulse(); pulse();
    model[10] = d2;
    rd_arr("R10 target written", 10);
    rd_arr("R10 no second program", 11);
    rd_arr("R10 no erase", 40);

    rd_arr("R6 before fail", 5);
    start_prog(5, 8'hFF);
    for (int k = 0; k < PM; k++) begin
      pulse();
      rd_stat("R6 before limit", 5, 1'b0, 1'b0, 1'b0);
    end
    pulse();
    rd_stat("R6 flag set", 5, 1'b0, 1'b1, 1'b0);
    rd_stat("R6 still toggling", 5, 1'b0, 1'b1, 1'b0);
    pulse(); pulse();
    rd_stat("R6 no completion", 5, 1'b0, 1'b1, 1'b0);
    start_chip();
    rd_stat("R10 fail ignores start", 5, 1'b0, 1'b1, 1'b0);
    rst_n = 1'b0; cyc(2); rst_n = 1'b1; tg = 1'b0;
    check("R1 reset after fail", rd_data, 8'h00);
    rd_arr("R6 byte unchanged", 5);
    rd_arr("R1 array kept", 6);
    start_prog(5, 8'h44);
    rd_stat("R1 toggle restarted", 5, 1'b1, 1'b0, 1'b0);
    pulse(); pulse();
    model[5] = 8'h44;
    rd_arr("R6 usable after reset", 5);

    start_sect(20);
    pulse(); pulse(); pulse();
    start_sect(50);
    rd_stat("R3 in selected sector", 20, 1'b0, 1'b0, 1'b0);
    rd_stat("R3 outside sector", 2, 1'b1, 1'b0, 1'b0);
    rd_stat("R8 added sector", 50, 1'b0, 1'b0, 1'b0);
    cyc(WIN - 4);
    rd_stat("R7 last open edge", 20, 1'b0, 1'b0, 1'b0);
    rd_stat("R7 window closed", 20, 1'b0, 1'b0, 1'b1);
    start_sect(2);
    rd_stat("R8 late command ignored", 2, 1'b1, 1'b0, 1'b1);
    pulse(); pulse();
    rd_stat("R9 window ticks ignored", 20, 1'b0, 1'b0, 1'b1);
    pulse();
    for (int i = 16; i < 32; i++) model[i] = 8'hFF;
    for (int i = 48; i < 64; i++) model[i] = 8'hFF;
    for (int i = 0; i < DEP; i++) rd_arr("R3 sector erase result", AW'(i));

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule